// File: doc/BRIEF.md
# Two-Level Read Cache Controller

This block puts a small, fast first-level line store and a larger, slower second-level line store in front of a main-memory read port. Both levels are direct-mapped, and each line holds one data word. The controller takes one read request at a time over a valid/ready handshake. It looks the address up in both levels and answers from the nearest level that holds it. When both levels miss, it fetches the line from memory. Each response carries a code that names the level which served it.

An elaboration-time parameter picks one of two ways of sharing lines between the levels. In inclusive operation the second level is a superset of the first. A second-level hit copies the line upward, and a miss in both levels fills both. In exclusive operation the second level only holds lines pushed out of the first level. A second-level hit swaps the two lines, and a miss in both levels fills the first level only. The line displaced from the first level cascades down, and whatever it replaces in the second level is discarded. The second-level index always contains the first-level index bits, so lines that collide in the second level also collide in the first.

Top module: `dual_level_cache`

## Requirements
- R1: Reset empties both levels. After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_rd` is 0, and the first read of any address is served from memory.
- R2: A request that hits the first level is accepted while `req_ready` is 1. The response appears on the next cycle with `resp_src` = 0 and the stored data.
- R3: A request that misses the first level and hits the second level responds 3 cycles after acceptance with `resp_src` = 1 and the line's data.
- R4: A request that misses both levels responds 8 cycles after acceptance with `resp_src` = 2 and `mem_rdata` data. Until then, `mem_rd` is 1 and `mem_addr` holds the request address steadily.
- R5: After a first-level miss is accepted, `req_ready` stays 0 and `resp_valid` stays 0 until the response cycle. `req_ready` is 1 again on the cycle after the response.
- R6: Inclusive mode: a second-level hit copies the line into the first level, so the next access to it is a first-level hit.
- R7: Inclusive mode: a miss in both levels places the line in both levels. A line that was evicted from the first level alone is then a second-level hit, and every first-level line is also present in the second level.
- R8: Inclusive mode: when a second-level line is replaced, any first-level copy of it is gone, so the next access to it goes to memory.
- R9: Exclusive mode: a miss in both levels fills only the first level. The first-level line it displaces moves into the second level and is then a second-level hit.
- R10: Exclusive mode: a second-level hit swaps the requested line with the first-level line at the same first-level index.
- R11: Exclusive mode: a second-level line overwritten by a cascading first-level victim is dropped, so the next access to it goes to memory.
- R12: Exclusive mode: no line is valid in both levels at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | ADDR_W | Line address of the request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DATA_W | Returned line data |
| resp_src | output | 2 | Serving level: 0 first level, 1 second level, 2 memory |
| mem_rd | output | 1 | Memory fetch in progress |
| mem_addr | output | ADDR_W | Line address being fetched |
| mem_rdata | input | DATA_W | Memory data for `mem_addr`, sampled when the fetch ends |

## Verification
Both modes are driven with directed streams of addresses that collide in the first level only (indices equal in the low two bits) and in both levels (equal low four bits). These streams separate a copy-up from a swap, and a cascade from a drop. A linear sweep over twice the second-level capacity, repeated once, shows whether the two modes keep different sets of lines resident. A behavioural reference model predicts the serving level, data and latency of every access. The response strobe, the ready signal and the memory port are compared against the model on every cycle of each access.

// File: rtl/dlc_pkg.sv
// Shared definitions for the two-level read cache.
// Assumes: the response source code is 2 bits wide on the top-level port.
package dlc_pkg;
    typedef enum logic [1:0] {
        SRC_L1  = 2'd0,
        SRC_L2  = 2'd1,
        SRC_MEM = 2'd2
    } src_e;
endpackage

// File: rtl/dlc_store.sv
// Direct-mapped line store: one word per line, valid/tag/data per set.
// Lookup is combinational on look_addr, and it also exposes the resident line
// at that index. One write and one invalidate per cycle; on the same index the
// write wins. Assumes IDX_W < ADDR_W.
module dlc_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_addr,
    output logic [DATA_W-1:0] res_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    logic [IDX_W-1:0]  look_idx;
    logic [IDX_W-1:0]  wr_idx;

    assign look_idx = look_addr[IDX_W-1:0];
    assign wr_idx   = wr_addr[IDX_W-1:0];

    // Read side: resident line at the looked-up index and the hit test.
    always_comb begin
        res_valid = valid_q[look_idx];
        res_addr  = {tag_q[look_idx], look_idx};
        res_data  = data_q[look_idx];
        hit       = res_valid && (tag_q[look_idx] == look_addr[ADDR_W-1:IDX_W]);
        hit_data  = data_q[look_idx];
    end

    // Valid bits: cleared by reset, invalidate first, write overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inv_en) valid_q[inv_idx] <= 1'b0;
            if (wr_en)  valid_q[wr_idx]  <= 1'b1;
        end
    end

    // Tag and data payload: written on fill, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_addr[ADDR_W-1:IDX_W];
            data_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/dlc_latency.sv
// Down-counter that models access latency. A load sets the remaining wait,
// and zero is flagged when the count is exhausted.
// Assumes load values fit in the derived width.
module dlc_latency #(
    parameter int MAX_WAIT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [$clog2(MAX_WAIT)-1:0]  load_val,
    output logic                         zero
);
    localparam int CNT_W = $clog2(MAX_WAIT);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/dual_level_cache.sv
// Two-level direct-mapped read cache controller with an inclusive or
// exclusive line policy chosen at elaboration (EXCLUSIVE). It serves one
// request at a time. A first-level hit answers next cycle; other requests
// block until the modeled latency ends, and all line moves happen on that
// final cycle. Assumes L2_IDX_W > L1_IDX_W (the second-level index contains
// the first-level index), 2 <= L2_LAT < MEM_LAT, and that mem_rdata follows
// mem_addr combinationally.
module dual_level_cache
    import dlc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int L1_IDX_W  = 2,
    parameter int L2_IDX_W  = 4,
    parameter int L2_LAT    = 3,
    parameter int MEM_LAT   = 8,
    parameter bit EXCLUSIVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic [1:0]        resp_src,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int CNT_W = $clog2(MEM_LAT);
    localparam logic [CNT_W-1:0] L2_WAIT  = CNT_W'(L2_LAT - 2);
    localparam logic [CNT_W-1:0] MEM_WAIT = CNT_W'(MEM_LAT - 2);

    logic              busy_q;
    logic [ADDR_W-1:0] cur_addr_q;
    src_e              cur_src_q;

    logic [ADDR_W-1:0] look_addr;
    logic              accept, fin, tmr_zero;

    logic              l1_hit, l1_res_valid;
    logic [DATA_W-1:0] l1_hit_data, l1_res_data;
    logic [ADDR_W-1:0] l1_res_addr;
    logic              l2_hit, l2_res_valid;
    logic [DATA_W-1:0] l2_hit_data, l2_res_data;
    logic [ADDR_W-1:0] l2_res_addr;

    logic [DATA_W-1:0] fill_data;
    logic              l2_wr_en, l2_inv_en;
    logic [ADDR_W-1:0] l2_wr_addr;
    logic [DATA_W-1:0] l2_wr_data;

    assign req_ready = !busy_q;
    assign accept    = req_valid && req_ready;
    assign look_addr = busy_q ? cur_addr_q : req_addr;
    assign fin       = busy_q && tmr_zero;
    assign fill_data = (cur_src_q == SRC_L2) ? l2_hit_data : mem_rdata;
    assign mem_rd    = busy_q && (cur_src_q == SRC_MEM);
    assign mem_addr  = cur_addr_q;

    dlc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(L1_IDX_W)) u_l1 (
        .clk(clk), .rst_n(rst_n), .look_addr(look_addr),
        .hit(l1_hit), .hit_data(l1_hit_data),
        .res_valid(l1_res_valid), .res_addr(l1_res_addr), .res_data(l1_res_data),
        .wr_en(fin), .wr_addr(cur_addr_q), .wr_data(fill_data),
        .inv_en(1'b0), .inv_idx('0)
    );

    dlc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(L2_IDX_W)) u_l2 (
        .clk(clk), .rst_n(rst_n), .look_addr(look_addr),
        .hit(l2_hit), .hit_data(l2_hit_data),
        .res_valid(l2_res_valid), .res_addr(l2_res_addr), .res_data(l2_res_data),
        .wr_en(l2_wr_en), .wr_addr(l2_wr_addr), .wr_data(l2_wr_data),
        .inv_en(l2_inv_en), .inv_idx(cur_addr_q[L2_IDX_W-1:0])
    );

    dlc_latency #(.MAX_WAIT(MEM_LAT)) u_lat (
        .clk(clk), .rst_n(rst_n),
        .load(accept && !l1_hit),
        .load_val(l2_hit ? L2_WAIT : MEM_WAIT),
        .zero(tmr_zero)
    );

    // Second-level update policy, chosen by the mode parameter.
    generate
        if (EXCLUSIVE) begin : g_excl
            // Victim store: the first-level line displaced at completion
            // cascades down; a second-level hit frees its slot (swap).
            always_comb begin
                l2_wr_en   = fin && l1_res_valid;
                l2_wr_addr = l1_res_addr;
                l2_wr_data = l1_res_data;
                l2_inv_en  = fin && (cur_src_q == SRC_L2);
            end
        end else begin : g_incl
            // Superset store: memory fills land in both levels. The replaced
            // second-level line shares the first-level index, so the L1 fill
            // removes any copy of it.
            always_comb begin
                l2_wr_en   = fin && (cur_src_q == SRC_MEM);
                l2_wr_addr = cur_addr_q;
                l2_wr_data = mem_rdata;
                l2_inv_en  = 1'b0;
            end
        end
    endgenerate

    // Request tracking: latch a first-level miss and release it at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            cur_addr_q <= '0;
            cur_src_q  <= SRC_L1;
        end else if (accept && !l1_hit) begin
            busy_q     <= 1'b1;
            cur_addr_q <= req_addr;
            cur_src_q  <= l2_hit ? SRC_L2 : SRC_MEM;
        end else if (fin) begin
            busy_q     <= 1'b0;
        end
    end

    // Response register: one-cycle strobe with data and serving level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
            resp_src   <= SRC_L1;
        end else begin
            resp_valid <= (accept && l1_hit) || fin;
            if (accept && l1_hit) begin
                resp_data <= l1_hit_data;
                resp_src  <= SRC_L1;
            end else if (fin) begin
                resp_data <= fill_data;
                resp_src  <= cur_src_q;
            end
        end
    end

    // R12: in exclusive mode, the looked-up line is never resident in both levels.
    p_excl_disjoint_r12: assert property (@(posedge clk) disable iff (!rst_n)
        EXCLUSIVE |-> !(l1_hit && l2_hit));

    // R7: in inclusive mode, any first-level hit is also a second-level hit.
    p_incl_superset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!EXCLUSIVE && l1_hit) |-> l2_hit);

    // R2: an accepted first-level hit is answered by the first level next cycle.
    p_l1_hit_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && l1_hit) |=> (resp_valid && resp_src == SRC_L1));

    // R5: an accepted first-level miss blocks new requests on the next cycle.
    p_miss_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !l1_hit) |=> (!req_ready && !resp_valid));

    // R4: the fetch address holds steady while a memory fetch is outstanding.
    p_mem_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> $stable(mem_addr));
endmodule

// File: tb/dual_level_cache_tb.sv
module dual_level_cache_tb;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int L1N = 4;
    localparam int L2N = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          rv [2];
    logic [AW-1:0] ra [2];
    logic          rr [2];
    logic          vv [2];
    logic [DW-1:0] vd [2];
    logic [1:0]    vs [2];
    logic          mr [2];
    logic [AW-1:0] ma [2];
    logic [DW-1:0] md [2];

    int n_chk  = 0;
    int n_fail = 0;
    int l1m [2][L1N];
    int l2m [2][L2N];

    function automatic logic [DW-1:0] mem_fn(input int a);
        return DW'(a * 41 + 16'h1234);
    endfunction

    always_comb begin
        for (int m = 0; m < 2; m++) md[m] = mem_fn(int'(ma[m]));
    end

    dual_level_cache #(.EXCLUSIVE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rr[0]),
        .req_addr(ra[0]), .resp_valid(vv[0]), .resp_data(vd[0]), .resp_src(vs[0]),
        .mem_rd(mr[0]), .mem_addr(ma[0]), .mem_rdata(md[0])
    );

    dual_level_cache #(.EXCLUSIVE(1'b1)) u_dut_x (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rr[1]),
        .req_addr(ra[1]), .resp_valid(vv[1]), .resp_data(vd[1]), .resp_src(vs[1]),
        .mem_rd(mr[1]), .mem_addr(ma[1]), .mem_rdata(md[1])
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: predicts the serving level and updates both levels.
    function automatic int model_access(input int m, input int a);
        int i1 = a % L1N;
        int i2 = a % L2N;
        int v;
        if (l1m[m][i1] == a) return 0;
        if (l2m[m][i2] == a) begin
            v = l1m[m][i1];
            l1m[m][i1] = a;
            if (m == 1) begin
                l2m[m][i2] = -1;
                if (v >= 0) l2m[m][v % L2N] = v;
            end
            return 1;
        end
        v = l1m[m][i1];
        l1m[m][i1] = a;
        if (m == 0) l2m[m][i2] = a;
        else if (v >= 0) l2m[m][v % L2N] = v;
        return 2;
    endfunction

    // Issue one request and compare the ports against the model on every cycle.
    task automatic access(input int m, input int a, output int got);
        int lvl, lat;
        string tag;
        lvl = model_access(m, a);
        lat = (lvl == 0) ? 1 : (lvl == 1) ? 3 : 8;
        tag = (lvl == 0) ? "R2" : (lvl == 1) ? "R3" : "R4";
        got = -1;
        @(negedge clk);
        chk(rr[m] == 1'b1, "R5", "ready before request", int'(rr[m]), 1);
        rv[m] = 1'b1;
        ra[m] = AW'(a);
        @(negedge clk);
        rv[m] = 1'b0;
        for (int c = 1; c <= lat; c++) begin
            if (c < lat) begin
                chk(vv[m] == 1'b0 && rr[m] == 1'b0, "R5", "busy wait (valid,ready)",
                    int'({vv[m], rr[m]}), 0);
                if (lvl == 2)
                    chk(mr[m] == 1'b1 && int'(ma[m]) == a, "R4", "mem fetch addr",
                        mr[m] ? int'(ma[m]) : -1, a);
                @(negedge clk);
            end else begin
                chk(vv[m] == 1'b1, tag, "resp_valid at latency", int'(vv[m]), 1);
                chk(int'(vs[m]) == lvl, tag, "resp_src", int'(vs[m]), lvl);
                chk(vd[m] == mem_fn(a), tag, "resp_data", int'(vd[m]), int'(mem_fn(a)));
                got = vv[m] ? int'(vs[m]) : -1;
            end
        end
    endtask

    task automatic expect_src(input int m, input int a, input int exp, input string tag);
        int got;
        access(m, a, got);
        chk(got == exp, tag, $sformatf("mode%0d addr 0x%0h source", m, a), got, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int got;
        for (int m = 0; m < 2; m++) begin
            rv[m] = 1'b0;
            ra[m] = '0;
            for (int i = 0; i < L1N; i++) l1m[m][i] = -1;
            for (int i = 0; i < L2N; i++) l2m[m][i] = -1;
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            chk(rr[m] == 1'b1, "R1", "ready after reset", int'(rr[m]), 1);
            chk(vv[m] == 1'b0, "R1", "resp_valid after reset", int'(vv[m]), 0);
            chk(mr[m] == 1'b0, "R1", "mem_rd after reset", int'(mr[m]), 0);
        end

        // Inclusive mode scenarios.
        expect_src(0, 'h05, 2, "R1");
        expect_src(0, 'h05, 0, "R2");
        expect_src(0, 'h09, 2, "R4");
        expect_src(0, 'h05, 1, "R7");
        expect_src(0, 'h05, 0, "R6");
        expect_src(0, 'h15, 2, "R4");
        expect_src(0, 'h05, 2, "R8");

        // Exclusive mode scenarios.
        expect_src(1, 'h05, 2, "R1");
        expect_src(1, 'h05, 0, "R2");
        expect_src(1, 'h09, 2, "R9");
        expect_src(1, 'h05, 1, "R9");
        expect_src(1, 'h09, 1, "R10");
        expect_src(1, 'h09, 0, "R12");
        expect_src(1, 'h05, 1, "R12");
        expect_src(1, 'h15, 2, "R4");
        expect_src(1, 'h25, 2, "R4");
        expect_src(1, 'h05, 2, "R11");

        // Sweeps in both modes, checked against the reference model.
        for (int m = 0; m < 2; m++)
            for (int pass = 0; pass < 2; pass++)
                for (int a = 0; a < 2 * L2N; a++) access(m, a, got);
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 40; a++) access(m, (a * 7) % 48, got);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule